// File: doc/BRIEF.md
# Homeostatic Firing Threshold Controller

This block keeps each neuron of a spiking layer near a target firing rate by adjusting that neuron's firing threshold. It counts the output spikes of every neuron across an evaluation period. The period is measured in stimulus presentations, not in clock cycles. When the period closes, the controller compares each neuron's count with a shared target count. A neuron that fired too often gets a higher threshold. A neuron that fired too rarely gets a lower one.

Each threshold is a 16-bit unsigned fixed-point value in which 0x8000 stands for 1.0, the largest value a neuron's state can reach. The size of a correction grows linearly with the count error. The error is first scaled so that one spike is worth 256 threshold LSBs. It is then divided by a configurable power of two. The neurons read the threshold outputs continuously.

Top module: `homeo_thresh_ctrl`

## Requirements
- R1: While reset is held and after it is released, every threshold output reads 0x4000 (0.5) until the first period closes.
- R2: A period closes on the clock edge that registers the EVAL_PRES-th presentation strobe since reset or since the last close. Thresholds change only on that edge.
- R3: At a close, a neuron whose count exceeds the target gets its threshold raised by ((count − target) × 256) arithmetically shifted right by the shift setting.
- R4: At a close, a neuron whose count is below the target gets its threshold lowered by the same formula, which gives a negative step.
- R5: At a close, a neuron whose count equals the target keeps its threshold unchanged.
- R6: Every threshold stays within [0x0200, 0x8000] (1/64 to 1.0). A step that would cross a bound stops at that bound.
- R7: A spike counter saturates at 255. Further spikes within the period have no effect on it.
- R8: Counters restart at each close after the update has been applied. A spike that arrives in the same cycle as the closing strobe counts toward the next period.
- R9: Each neuron's count and threshold are independent of the other neurons' spikes.
- R10: The shift rounds toward minus infinity. A negative error that is shifted past all of its bits still lowers the threshold by one LSB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| spike_i | input | N_NEURONS | One-cycle spike strobe per neuron |
| pres_done_i | input | 1 | One-cycle strobe marking the end of a stimulus presentation |
| cfg_target_i | input | CNT_W | Target spike count per evaluation period |
| cfg_shift_i | input | 4 | Right-shift amount (0 to 15) applied to the scaled error |
| thresh_o | output | N_NEURONS × 16 | Current firing threshold of each neuron, 0x8000 = 1.0 |

## Verification
The hardest situation to reach is a spike that lands exactly on the closing presentation strobe. It must be credited to the next period while the update still uses the old count. The stimulus asserts a spike together with the final strobe of a period that is otherwise balanced. In the following period it supplies one spike fewer than the target, so a threshold that holds proves the carry and a threshold that drops exposes a lost spike. Saturation and both clamps are reached with a zero shift and extreme targets over a few consecutive periods. The round-toward-minus-infinity case uses a count one below target with the maximum shift.

// File: rtl/hth_pkg.sv
package hth_pkg;

    // Threshold fixed-point format: unsigned, 1.0 == 2**FRAC_W
    localparam int TH_W      = 16;
    localparam int FRAC_W    = 15;
    localparam int SHIFT_W   = 4;
    // One spike of error maps to 2**ERR_SCALE threshold LSBs
    localparam int ERR_SCALE = 8;

    localparam logic [TH_W-1:0] TH_INIT = 16'h4000;  // 0.5
    localparam logic [TH_W-1:0] TH_MIN  = 16'h0200;  // 1/64
    localparam logic [TH_W-1:0] TH_MAX  = 16'h8000;  // 1.0

    typedef logic [TH_W-1:0] thresh_t;

    typedef enum logic [1:0] {
        DIR_HOLD  = 2'd0,
        DIR_RAISE = 2'd1,
        DIR_LOWER = 2'd2
    } adj_dir_e;

endpackage

// File: rtl/hth_period_timer.sv
module hth_period_timer #(
    parameter int EVAL_PRES = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pres_done_i,
    output logic period_end_o
);
    localparam int PW = (EVAL_PRES > 1) ? $clog2(EVAL_PRES) : 1;
    localparam logic [PW-1:0] LAST = PW'(EVAL_PRES - 1);

    typedef struct packed {
        logic [PW-1:0] pres_cnt;
    } tmr_st_t;

    tmr_st_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        period_end_o = 1'b0;
        if (pres_done_i) begin
            if (st_q.pres_cnt == LAST) begin
                period_end_o    = 1'b1;
                st_d.pres_cnt   = '0;
            end else begin
                st_d.pres_cnt   = st_q.pres_cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/hth_spike_ctr.sv
module hth_spike_ctr #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             spike_i,
    input  logic             clear_i,
    output logic [CNT_W-1:0] count_o
);
    localparam logic [CNT_W-1:0] CNT_SAT = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } ctr_st_t;

    ctr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear_i) begin
            // boundary spike is credited to the period that starts now
            st_d.cnt = spike_i ? CNT_W'(1) : '0;
        end else if (spike_i && (st_q.cnt != CNT_SAT)) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count_o = st_q.cnt;
endmodule

// File: rtl/hth_thresh_calc.sv
module hth_thresh_calc
    import hth_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  thresh_t             th_i,
    input  logic [CNT_W-1:0]    count_i,
    input  logic [CNT_W-1:0]    target_i,
    input  logic [SHIFT_W-1:0]  shift_i,
    output thresh_t             th_o,
    output adj_dir_e            dir_o
);
    localparam int ERR_W   = CNT_W + 1;
    localparam int STEP_W  = ERR_W + ERR_SCALE;
    localparam int SUM_W   = TH_W + STEP_W + 1;
    localparam logic signed [SUM_W-1:0] S_MIN = SUM_W'({1'b0, TH_MIN});
    localparam logic signed [SUM_W-1:0] S_MAX = SUM_W'({1'b0, TH_MAX});

    logic signed [ERR_W-1:0]  err;
    logic signed [STEP_W-1:0] scaled;
    logic signed [STEP_W-1:0] step;
    logic signed [SUM_W-1:0]  sum;

    always_comb begin
        err    = $signed({1'b0, count_i}) - $signed({1'b0, target_i});
        scaled = {err, {ERR_SCALE{1'b0}}};
        step   = scaled >>> shift_i;
        sum    = $signed(SUM_W'({1'b0, th_i})) + SUM_W'(step);

        if (err == '0)        dir_o = DIR_HOLD;
        else if (err[ERR_W-1]) dir_o = DIR_LOWER;
        else                  dir_o = DIR_RAISE;

        if (dir_o == DIR_HOLD)   th_o = th_i;
        else if (sum > S_MAX)    th_o = TH_MAX;
        else if (sum < S_MIN)    th_o = TH_MIN;
        else                     th_o = sum[TH_W-1:0];
    end
endmodule

// File: rtl/homeo_thresh_ctrl.sv
module homeo_thresh_ctrl
    import hth_pkg::*;
#(
    parameter int N_NEURONS = 4,
    parameter int CNT_W     = 8,
    parameter int EVAL_PRES = 100
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [N_NEURONS-1:0]           spike_i,
    input  logic                           pres_done_i,
    input  logic [CNT_W-1:0]               cfg_target_i,
    input  logic [3:0]                     cfg_shift_i,
    output logic [N_NEURONS-1:0][TH_W-1:0] thresh_o
);
    typedef struct packed {
        logic [N_NEURONS-1:0][TH_W-1:0] th;
    } top_st_t;

    top_st_t                          st_d, st_q;
    logic                             period_end;
    logic [N_NEURONS-1:0][CNT_W-1:0]  cnt_q;
    logic [N_NEURONS-1:0][TH_W-1:0]   th_next;
    adj_dir_e                         dir [N_NEURONS];

    hth_period_timer #(.EVAL_PRES(EVAL_PRES)) u_timer (
        .clk          (clk),
        .rst_n        (rst_n),
        .pres_done_i  (pres_done_i),
        .period_end_o (period_end)
    );

    for (genvar g = 0; g < N_NEURONS; g++) begin : g_neuron
        hth_spike_ctr #(.CNT_W(CNT_W)) u_ctr (
            .clk     (clk),
            .rst_n   (rst_n),
            .spike_i (spike_i[g]),
            .clear_i (period_end),
            .count_o (cnt_q[g])
        );

        hth_thresh_calc #(.CNT_W(CNT_W)) u_calc (
            .th_i     (st_q.th[g]),
            .count_i  (cnt_q[g]),
            .target_i (cfg_target_i),
            .shift_i  (cfg_shift_i),
            .th_o     (th_next[g]),
            .dir_o    (dir[g])
        );
    end

    always_comb begin
        st_d = st_q;
        if (period_end) begin
            for (int i = 0; i < N_NEURONS; i++) begin
                st_d.th[i] = th_next[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q.th <= {N_NEURONS{TH_INIT}};
        else        st_q    <= st_d;
    end

    assign thresh_o = st_q.th;
endmodule

// File: rtl/hth_checker.sv
module hth_checker
    import hth_pkg::*;
#(
    parameter int N_NEURONS = 4,
    parameter int CNT_W     = 8
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic [N_NEURONS-1:0]           spike_i,
    input logic                           period_end,
    input logic [CNT_W-1:0]               cfg_target_i,
    input logic [N_NEURONS-1:0][CNT_W-1:0] cnt_q,
    input logic [N_NEURONS-1:0][TH_W-1:0] thresh_o
);
    localparam logic [CNT_W-1:0] SAT = '1;

    for (genvar g = 0; g < N_NEURONS; g++) begin : g_chk
        p_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (thresh_o[g] >= TH_MIN) && (thresh_o[g] <= TH_MAX));

        p_only_at_close_r2: assert property (@(posedge clk) disable iff (!rst_n)
            !period_end |=> $stable(thresh_o[g]));

        p_raise_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (period_end && (cnt_q[g] > cfg_target_i)) |=> (thresh_o[g] >= $past(thresh_o[g])));

        p_lower_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (period_end && (cnt_q[g] < cfg_target_i)) |=> (thresh_o[g] <= $past(thresh_o[g])));

        p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (period_end && (cnt_q[g] == cfg_target_i)) |=> $stable(thresh_o[g]));

        p_saturate_r7: assert property (@(posedge clk) disable iff (!rst_n)
            ((cnt_q[g] == SAT) && !period_end) |=> (cnt_q[g] == SAT));

        p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (period_end && !spike_i[g]) |=> (cnt_q[g] == '0));

        p_credit_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (period_end && spike_i[g]) |=> (cnt_q[g] == CNT_W'(1)));
    end
endmodule

bind homeo_thresh_ctrl hth_checker #(
    .N_NEURONS (N_NEURONS),
    .CNT_W     (CNT_W)
) u_hth_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .spike_i      (spike_i),
    .period_end   (period_end),
    .cfg_target_i (cfg_target_i),
    .cnt_q        (cnt_q),
    .thresh_o     (thresh_o)
);

// File: tb/sim_homeo_thresh_ctrl.sv
`timescale 1ns/1ps
module sim_homeo_thresh_ctrl;
    localparam int N  = 4;
    localparam int CW = 8;
    localparam int EV = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [N-1:0]      spike = '0;
    logic              pres = 1'b0;
    logic [CW-1:0]     tgt = 8'd10;
    logic [3:0]        sh = 4'd4;
    logic [N-1:0][15:0] th;

    int checks = 0;
    int fails  = 0;
    int mth [N];
    int mcnt [N];
    bit carried [N];

    typedef struct {
        int    idx;
        int    val;
        string req;
    } item_t;
    item_t sb_q [$];
    event  sb_ev;

    always #2.5 clk = ~clk;

    homeo_thresh_ctrl #(.N_NEURONS(N), .CNT_W(CW), .EVAL_PRES(EV)) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .spike_i      (spike),
        .pres_done_i  (pres),
        .cfg_target_i (tgt),
        .cfg_shift_i  (sh),
        .thresh_o     (th)
    );

    task automatic chk(string req, int got, int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", req, got, exp);
        end
    endtask

    // monitor: pops expected items and compares with the outputs
    initial begin
        forever begin
            @(sb_ev);
            while (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                chk(it.req, int'(th[it.idx]), it.val);
            end
        end
    end

    task automatic push_all(string req);
        for (int i = 0; i < N; i++) begin
            item_t it;
            it.idx = i; it.val = mth[i]; it.req = req;
            sb_q.push_back(it);
        end
        -> sb_ev;
    endtask

    // reference model of the period close, from the requirements
    task automatic close_model(bit bspk);
        for (int i = 0; i < N; i++) begin
            item_t it;
            int c, d, n;
            string tag;
            c = (mcnt[i] > 255) ? 255 : mcnt[i];
            d = ((c - int'(tgt)) * 256) >>> int'(sh);
            n = mth[i] + d;
            if (c > int'(tgt))      tag = "R3";
            else if (c < int'(tgt)) tag = "R4";
            else                    tag = "R5";
            if (mcnt[i] > 255) tag = "R7";
            if (d == -1)       tag = "R10";
            if (carried[i])    tag = "R8";
            if (c != int'(tgt)) begin
                if (n > 32768) begin n = 32768; tag = "R6"; end
                if (n < 512)   begin n = 512;   tag = "R6"; end
                mth[i] = n;
            end
            it.idx = i; it.val = mth[i]; it.req = tag;
            sb_q.push_back(it);
            carried[i] = (i == 0) && bspk;
            mcnt[i]    = carried[i] ? 1 : 0;
        end
        -> sb_ev;
    endtask

    // driver: one evaluation period; starts and ends at a falling edge
    task automatic run_period(int sp [N], bit bspk);
        int mx = 0;
        for (int i = 0; i < N; i++) if (sp[i] > mx) mx = sp[i];
        for (int c = 0; c < mx; c++) begin
            for (int i = 0; i < N; i++) spike[i] = (c < sp[i]);   // R9 distinct per neuron
            @(negedge clk);
        end
        spike = '0;
        for (int i = 0; i < N; i++) mcnt[i] += sp[i];
        for (int p = 0; p < EV; p++) begin
            if (p == EV - 1) push_all("R2");
            pres = 1'b1;
            if (p == EV - 1) spike[0] = bspk;
            @(negedge clk);
            pres  = 1'b0;
            spike = '0;
            @(negedge clk);
        end
        close_model(bspk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) begin
            mth[i] = 16'h4000; mcnt[i] = 0; carried[i] = 1'b0;
        end
        repeat (3) @(negedge clk);
        push_all("R1");
        rst_n = 1'b1;
        @(negedge clk);
        push_all("R1");

        tgt = 8'd10;  sh = 4'd4;  run_period('{20, 10, 5, 0}, 1'b0);
        tgt = 8'd250; sh = 4'd0;  run_period('{300, 250, 0, 0}, 1'b0);
        tgt = 8'd0;   sh = 4'd0;  run_period('{200, 0, 0, 0}, 1'b0);
        tgt = 8'd10;  sh = 4'd15; run_period('{9, 9, 11, 10}, 1'b0);
        tgt = 8'd2;   sh = 4'd0;  run_period('{2, 2, 2, 2}, 1'b1);
        tgt = 8'd2;   sh = 4'd0;  run_period('{1, 2, 2, 3}, 1'b0);
        tgt = 8'd5;   sh = 4'd2;  run_period('{5, 0, 30, 6}, 1'b0);

        repeat (4) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule